// File: doc/BRIEF.md
# Home-Node Cache Directory Controller

This block is the coherence directory of one home node in a machine whose memory is spread over many nodes. Each read request names a physical address and the node that issued it. The controller splits the address into a home-node field, a line field and a byte offset. For every line homed here it keeps one directory entry, which records whether some cache holds the line and which single node that is.

For a line that no cache holds, the controller starts a local-RAM read, sends a data reply to the requester and records the requester as the holder. For a line held by a different node, it names the requester as the new holder. It then sends the old holder a forward-and-invalidate message, so that node passes its copy on and drops it. Requests that belong to another home node, or that name a line outside the local directory, are refused with a one-cycle error pulse.

Only one request is in flight at a time. A valid/ready handshake guards the request port, the RAM read port and the message port.

Top module: `dir_home_ctrl`

## Requirements
- R1: The address is decoded with the home node in bits 31:24, the line number in bits 23:6 and the byte offset in bits 5:0. The offset has no effect, and outgoing RAM reads and messages carry bits 23:6 as the line number.
- R2: After reset, every directory entry reads as not cached, `req_ready` is 1, and `mem_rd_valid`, `msg_valid` and `req_err` are 0.
- R3: A request for a line that is not cached issues one RAM read of that line and then one message of kind 0 (data reply) whose destination and requester are both the requesting node. The entry then names the requester as holder.
- R4: A request for a line held by another node issues no RAM read. It sends one message of kind 1 (forward-invalidate) with the destination set to the old holder, the requester set to the requesting node, and the line number. The entry then names the requester.
- R5: A request from the node already recorded as holder is answered like an uncached line: a RAM read, then a data reply. No forward-invalidate is sent and the entry is left unchanged.
- R6: A request whose home-node field differs from `node_id` raises `req_err` for exactly one cycle. It produces no RAM read and no message, and it leaves the directory unchanged.
- R7: A request whose line field is equal to or above the directory size `NUM_LINES` is refused in the same way as R6.
- R8: From the cycle after a request is accepted until its outgoing message is accepted, `req_ready` stays 0. The RAM read and the message valid signals are never both high.
- R9: The directory lookup takes one fixed cycle. The first RAM read or message valid appears in the second cycle after the accepting clock edge.
- R10: While `mem_rd_valid` or `msg_valid` waits for its ready signal, the valid signal stays high and its payload stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_id | input | 8 | Number of this home node |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 32 | Physical address of the request |
| req_src | input | 8 | Requesting node |
| req_err | output | 1 | One-cycle pulse for a refused request |
| mem_rd_valid | output | 1 | Local-RAM read request |
| mem_rd_ready | input | 1 | RAM accepts the read |
| mem_rd_line | output | 18 | Line to read |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_kind | output | 1 | 0 data reply, 1 forward-invalidate |
| msg_dst | output | 8 | Destination node |
| msg_req | output | 8 | Requesting node |
| msg_line | output | 18 | Line number |

## Verification
The hardest case to reach is a handover of ownership. The directory state is not visible at the ports, so each entry is revealed by a follow-up request from a third node: the destination of the resulting forward-invalidate names the stored holder. The same probe runs after refused requests and after a request from the current holder, to show that the entry did not move. Backpressure is tested by holding the RAM and message ready signals low for several cycles.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int ADDR_W = 32;
    localparam int NODE_W = 8;
    localparam int LINE_W = 18;
    localparam int OFF_W  = 6;

    typedef enum logic {
        MSG_DATA    = 1'b0,
        MSG_FWD_INV = 1'b1
    } msg_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOOK = 2'd1,
        S_RAM  = 2'd2,
        S_MSG  = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic              held;
        logic [NODE_W-1:0] owner;
    } dir_ent_t;
endpackage

// File: rtl/dir_addr_split.sv
module dir_addr_split
    import dir_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NODE_W-1:0] my_node,
    output logic [LINE_W-1:0] line_field,
    output logic [IDX_W-1:0]  idx,
    output logic              home_ok,
    output logic              line_ok
);
    logic [NODE_W-1:0] home_field;
    logic [OFF_W-1:0]  unused_off;

    always_comb begin
        home_field = addr[ADDR_W-1 -: NODE_W];
        line_field = addr[OFF_W +: LINE_W];
        unused_off = addr[OFF_W-1:0];
        idx        = line_field[IDX_W-1:0];
        home_ok    = (home_field == my_node);
        line_ok    = ({{(32-LINE_W){1'b0}}, line_field} < 32'(NUM_LINES));
    end
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store
    import dir_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output dir_ent_t         rd_ent,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  dir_ent_t         wr_ent
);
    dir_ent_t ent_d [NUM_LINES];
    dir_ent_t ent_q [NUM_LINES];

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && (32'(wr_idx) == 32'(i))) begin
                ent_d[i] = wr_ent;
            end
        end
        rd_ent = ent_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    AST_WR_MARKS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_ent.held) else $error("write clears held flag"); // R3
endmodule

// File: rtl/dir_ctrl_fsm.sv
module dir_ctrl_fsm
    import dir_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NODE_W-1:0] req_src,
    input  logic [LINE_W-1:0] line_field,
    input  logic [IDX_W-1:0]  idx,
    input  logic              home_ok,
    input  logic              line_ok,
    output logic              req_ready,
    output logic              req_err,
    output logic [IDX_W-1:0]  lk_idx,
    input  dir_ent_t          lk_ent,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output dir_ent_t          wr_ent,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [LINE_W-1:0] mem_rd_line,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_kind,
    output logic [NODE_W-1:0] msg_dst,
    output logic [NODE_W-1:0] msg_req,
    output logic [LINE_W-1:0] msg_line
);
    typedef struct packed {
        ctl_state_t        state;
        logic [LINE_W-1:0] line;
        logic [IDX_W-1:0]  idx;
        logic [NODE_W-1:0] src;
        msg_kind_t         kind;
        logic [NODE_W-1:0] dst;
        logic              err;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.err = 1'b0;
        wr_en   = 1'b0;
        wr_ent  = '0;
        case (c_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    if (home_ok && line_ok) begin
                        c_d.state = S_LOOK;
                        c_d.line  = line_field;
                        c_d.idx   = idx;
                        c_d.src   = req_src;
                    end else begin
                        c_d.err = 1'b1;
                    end
                end
            end
            S_LOOK: begin
                if (!lk_ent.held) begin
                    wr_en        = 1'b1;
                    wr_ent.held  = 1'b1;
                    wr_ent.owner = c_q.src;
                    c_d.state    = S_RAM;
                end else if (lk_ent.owner == c_q.src) begin
                    c_d.state = S_RAM;
                end else begin
                    wr_en        = 1'b1;
                    wr_ent.held  = 1'b1;
                    wr_ent.owner = c_q.src;
                    c_d.kind     = MSG_FWD_INV;
                    c_d.dst      = lk_ent.owner;
                    c_d.state    = S_MSG;
                end
            end
            S_RAM: begin
                if (mem_rd_ready) begin
                    c_d.kind  = MSG_DATA;
                    c_d.dst   = c_q.src;
                    c_d.state = S_MSG;
                end
            end
            S_MSG: begin
                if (msg_ready) begin
                    c_d.state = S_IDLE;
                end
            end
            default: c_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        req_ready    = (c_q.state == S_IDLE);
        req_err      = c_q.err;
        lk_idx       = c_q.idx;
        wr_idx       = c_q.idx;
        mem_rd_valid = (c_q.state == S_RAM);
        mem_rd_line  = c_q.line;
        msg_valid    = (c_q.state == S_MSG);
        msg_kind     = c_q.kind;
        msg_dst      = c_q.dst;
        msg_req      = c_q.src;
        msg_line     = c_q.line;
    end

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || msg_valid) |-> !req_ready) else $error("accepting while busy"); // R8
    AST_ONE_PORT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && msg_valid)) else $error("two outputs valid"); // R8
    AST_LOOKUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == S_LOOK) |=> (mem_rd_valid || msg_valid)) else $error("lookup too long"); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!mem_rd_valid && !msg_valid)) else $error("refused request acted"); // R6
    AST_FWD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_FWD_INV) |-> (msg_dst != msg_req)) else $error("forward to requester"); // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_line))) else $error("ram read dropped"); // R10
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dst) && $stable(msg_kind)
            && $stable(msg_line) && $stable(msg_req))) else $error("message dropped"); // R10
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] node_id,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NODE_W-1:0] req_src,
    output logic              req_err,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [LINE_W-1:0] mem_rd_line,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_kind,
    output logic [NODE_W-1:0] msg_dst,
    output logic [NODE_W-1:0] msg_req,
    output logic [LINE_W-1:0] msg_line
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [LINE_W-1:0] line_field;
    logic [IDX_W-1:0]  dec_idx;
    logic              home_ok;
    logic              line_ok;
    logic [IDX_W-1:0]  lk_idx;
    dir_ent_t          lk_ent;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    dir_ent_t          wr_ent;

    dir_addr_split #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_split (
        .addr       (req_addr),
        .my_node    (node_id),
        .line_field (line_field),
        .idx        (dec_idx),
        .home_ok    (home_ok),
        .line_ok    (line_ok)
    );

    dir_entry_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_ent (lk_ent),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent)
    );

    dir_ctrl_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_src      (req_src),
        .line_field   (line_field),
        .idx          (dec_idx),
        .home_ok      (home_ok),
        .line_ok      (line_ok),
        .req_ready    (req_ready),
        .req_err      (req_err),
        .lk_idx       (lk_idx),
        .lk_ent       (lk_ent),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_ent       (wr_ent),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_line  (mem_rd_line),
        .msg_valid    (msg_valid),
        .msg_ready    (msg_ready),
        .msg_kind     (msg_kind),
        .msg_dst      (msg_dst),
        .msg_req      (msg_req),
        .msg_line     (msg_line)
    );
endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  node_id = 8'd36;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_src = '0;
    logic        req_err;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [17:0] mem_rd_line;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic        msg_kind;
    logic [7:0]  msg_dst;
    logic [7:0]  msg_req;
    logic [17:0] msg_line;

    int tests = 0;
    int fails = 0;

    int          seen_mem, seen_msg, err_cnt, lat, busy_bad;
    logic [17:0] r_mem_line, r_line;
    logic [7:0]  r_dst, r_req;
    logic        r_kind;

    always #5 clk = ~clk;

    dir_home_ctrl #(.NUM_LINES(16)) u_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_src(req_src), .req_err(req_err),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_line(mem_rd_line),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dst(msg_dst), .msg_req(msg_req), .msg_line(msg_line)
    );

    function automatic logic [31:0] mk(input logic [7:0] nd, input logic [17:0] ln, input logic [5:0] off);
        return {nd, ln, off};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic [31:0] a, input logic [7:0] s);
        int done;
        seen_mem = 0; seen_msg = 0; err_cnt = 0; lat = 0; busy_bad = 0; done = 0;
        r_mem_line = '0; r_line = '0; r_dst = '0; r_req = '0; r_kind = 1'b0;
        @(negedge clk);
        req_addr = a; req_src = s; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (req_err) err_cnt++;
            if (done == 0 && err_cnt == 0 && req_ready) busy_bad = 1;
            if (mem_rd_valid) begin
                if (lat == 0) lat = i;
                seen_mem++;
                r_mem_line = mem_rd_line;
            end
            if (msg_valid) begin
                if (lat == 0) lat = i;
                seen_msg++;
                r_kind = msg_kind; r_dst = msg_dst; r_req = msg_req; r_line = msg_line;
                if (msg_ready) done = 1;
            end
        end
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R2 ready after reset", 32'(req_ready), 1);
        check(!mem_rd_valid && !msg_valid && !req_err, "R2 outputs idle after reset",
              {29'd0, mem_rd_valid, msg_valid, req_err}, 0);
    endtask

    task automatic t_uncached;
        xact(32'h2400_0108, 8'd20);
        check(seen_mem == 1 && r_mem_line == 18'd4, "R3 RAM read of line 4", r_mem_line, 4);
        check(seen_msg == 1 && r_kind == 1'b0 && r_dst == 8'd20 && r_req == 8'd20,
              "R3 data reply to node 20", {23'd0, r_kind, r_dst}, {23'd0, 1'b0, 8'd20});
        check(r_line == 18'd4, "R1 line decoded from 0x24000108", r_line, 4);
        check(lat == 2, "R9 first output two cycles after accept", lat, 2);
        check(busy_bad == 0, "R8 ready low while busy", busy_bad, 0);
    endtask

    task automatic t_handover;
        xact(mk(8'd36, 18'd2, 6'd0), 8'd82);
        check(seen_mem == 1 && r_dst == 8'd82 && r_kind == 1'b0, "R3 line 2 to node 82", r_dst, 82);
        xact(mk(8'd36, 18'd2, 6'd12), 8'd20);
        check(seen_mem == 0, "R4 no RAM read on held line", seen_mem, 0);
        check(r_kind == 1'b1 && r_dst == 8'd82 && r_req == 8'd20 && r_line == 18'd2,
              "R4 forward-invalidate to 82 for 20", {r_kind, r_dst, r_req}, {1'b1, 8'd82, 8'd20});
        check(lat == 2, "R9 forward latency", lat, 2);
        xact(mk(8'd36, 18'd2, 6'd0), 8'd82);
        check(r_kind == 1'b1 && r_dst == 8'd20, "R4 entry now names node 20", r_dst, 20);
    endtask

    task automatic t_same_holder;
        xact(32'h2400_0108, 8'd20);
        check(seen_mem == 1 && seen_msg == 1 && r_kind == 1'b0 && r_dst == 8'd20,
              "R5 holder re-read gets data reply", {r_kind, r_dst}, {1'b0, 8'd20});
        xact(32'h2400_0100, 8'd7);
        check(r_kind == 1'b1 && r_dst == 8'd20, "R5 entry unchanged after re-read", r_dst, 20);
    endtask

    task automatic t_wrong_home;
        xact(mk(8'd37, 18'd4, 6'd0), 8'd3);
        check(err_cnt == 1, "R6 one error pulse", err_cnt, 1);
        check(seen_mem == 0 && seen_msg == 0, "R6 no read or message", seen_mem + seen_msg, 0);
        xact(mk(8'd36, 18'd4, 6'd0), 8'd3);
        check(err_cnt == 0 && r_kind == 1'b1 && r_dst == 8'd7, "R6 directory unchanged", r_dst, 7);
    endtask

    task automatic t_out_of_range;
        xact(mk(8'd36, 18'd16, 6'd0), 8'd5);
        check(err_cnt == 1 && seen_mem == 0 && seen_msg == 0, "R7 line 16 refused", err_cnt, 1);
        xact(mk(8'd36, 18'h3FFFF, 6'd0), 8'd5);
        check(err_cnt == 1 && seen_mem == 0 && seen_msg == 0, "R7 top line refused", err_cnt, 1);
    endtask

    task automatic t_offset;
        xact(mk(8'd36, 18'd9, 6'h3F), 8'd5);
        check(r_mem_line == 18'd9 && r_line == 18'd9 && r_dst == 8'd5, "R1 offset ignored", r_line, 9);
        xact(mk(8'd36, 18'd9, 6'h00), 8'd6);
        check(r_kind == 1'b1 && r_dst == 8'd5, "R1 offset 0 hits same entry", r_dst, 5);
    endtask

    task automatic t_stall;
        mem_rd_ready = 1'b0; msg_ready = 1'b0;
        @(negedge clk);
        req_addr = mk(8'd36, 18'd7, 6'd0); req_src = 8'd11; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_rd_valid && mem_rd_line == 18'd7, "R10 RAM read held", mem_rd_line, 7);
            check(!req_ready, "R8 busy during RAM stall", 32'(req_ready), 0);
        end
        mem_rd_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(msg_valid && !mem_rd_valid && msg_dst == 8'd11 && msg_kind == 1'b0,
                  "R10 message held", msg_dst, 11);
        end
        msg_ready = 1'b1;
        @(negedge clk);
        check(req_ready && !msg_valid, "R8 ready after message accepted", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uncached();
        t_handover();
        t_same_holder();
        t_wrong_home();
        t_out_of_range();
        t_offset();
        t_stall();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule